// File: doc/BRIEF.md
# Calorimeter Tower Classifier and Missing-Energy Accumulator

This block takes calorimeter trigger data one cable word at a time. Each 40-bit word carries two neighbouring towers, and each tower has a 10-bit electromagnetic field and a 10-bit hadronic field. For each tower the block adds the two fields at full resolution to form a transverse energy. It then labels the tower as a cluster seed, a cluster shoulder or neither, by comparing that energy with two programmable thresholds. Towers with zero energy are dropped. Every remaining tower leaves on one of two output lanes, tagged with its eta and phi position.

The same pass also builds event totals. These are the scalar energy sum and the two fixed-point components of missing transverse energy, each weighted by a cosine or sine value chosen by the tower's phi. The word flagged as the last of an event ends the event. One cycle later the block presents the totals with a single-cycle strobe and restarts its accumulators from zero for the next event. Software clustering downstream then works only on the compact tower list and the ready-made totals.

Top module: `tower_sift`

## Requirements
- R1: After reset, both lanes are invalid, `evt_done` is low, `met_x`, `met_y` and `sum_et` are zero, the seed threshold is 24 and the shoulder threshold is 4 (energy LSB units, i.e. 3 GeV and 0.5 GeV at 0.125 GeV per LSB).
- R2: In `word_data`, bits [9:0] hold the EM energy and bits [19:10] the HAD energy of lane 0, and bits [29:20] hold the EM energy and bits [39:30] the HAD energy of lane 1. The energy of a tower is the unsigned 11-bit sum of its EM and HAD fields, with no truncation. Lane l reports its energy on `tw_et[11*l+10:11*l]`.
- R3: A reported tower has its seed flag set exactly when its energy is at or above the seed threshold that was in force when its word was accepted.
- R4: A reported tower has its shoulder flag set exactly when it is not a seed and its energy is at or above the shoulder threshold. The two flags are never set together, and neither is set on an invalid lane.
- R5: A tower whose energy is zero produces no output: its lane valid bit stays low.
- R6: Cable index c (0 to 287) maps to phi = c / 12 and to eta = 2*(c mod 12) for lane 0 and that value plus 1 for lane 1. Each lane reports its position on `tw_eta[5*l+4:5*l]` and `tw_phi[5*l+4:5*l]`. A word with a cable index of 288 or more adds nothing to any output or total.
- R7: Lane outputs for an accepted word appear exactly one cycle after the clock edge that accepts it, and last for one cycle only. A cycle with `word_valid` low produces no lane output and leaves the totals unchanged.
- R8: `sum_et` equals the sum of the energies of all towers accepted in the event.
- R9: `met_x` and `met_y` equal the sum over the event's towers of energy times C(phi) and energy times S(phi). Here C(p) = floor(cos(2*pi*(p+0.5)/24)*1024+0.5) and S(p) is the same with sin, so the results are signed and scaled by 1024.
- R10: `evt_done` pulses for one cycle, one cycle after a word with `word_last` high is accepted, and that word is counted in the totals. The next event's totals start from zero.
- R11: A write with `thr_we` high loads `thr_wdata` into the shoulder threshold when `thr_sel` is 1 and into the seed threshold when `thr_sel` is 0. The new value applies to the words accepted after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_we | input | 1 | Threshold write enable |
| thr_sel | input | 1 | 0 selects the seed threshold, 1 selects the shoulder threshold |
| thr_wdata | input | 11 | Threshold value in energy LSB |
| word_valid | input | 1 | Cable word present |
| word_data | input | 40 | Two towers, each given as an EM field and a HAD field |
| word_cable | input | 9 | Cable index |
| word_last | input | 1 | Last word of the event |
| tw_valid | output | 2 | Per-lane valid tower |
| tw_et | output | 22 | Per-lane tower energy |
| tw_eta | output | 10 | Per-lane eta index |
| tw_phi | output | 10 | Per-lane phi index |
| tw_seed | output | 2 | Per-lane seed flag |
| tw_shoulder | output | 2 | Per-lane shoulder flag |
| evt_done | output | 1 | End-of-event strobe |
| met_x | output | 32 | Signed x component of missing energy, scaled by 1024 |
| met_y | output | 32 | Signed y component of missing energy, scaled by 1024 |
| sum_et | output | 24 | Scalar energy sum of the event |

## Verification
A stale threshold register or a wrong field slice shows up on the very next accepted word as a wrong flag or energy on a lane. A wrong cable-to-position mapping shows up the same way, as a wrong eta or phi. A bad accumulator or a wrong trigonometric entry stays hidden until the end of the event, and then shows in `met_x`, `met_y` or `sum_et` at the `evt_done` strobe. An accumulator that fails to clear corrupts every event after the first. For that reason the stimulus runs many short random events back to back. It also drives directed words at the exact threshold boundaries, at the full 10-bit field range and with cable indices outside the valid range.

// File: rtl/tower_sift.sv
module tower_sift #(
  parameter int E_W       = 10,
  parameter int N_ETA     = 24,
  parameter int N_PHI     = 24,
  parameter int CAB_W     = 9,
  parameter int IDX_W     = 5,
  parameter int TRIG_W    = 12,
  parameter int TRIG_FRAC = 10,
  parameter int ACC_W     = 32,
  parameter int SUM_W     = 24,
  parameter int SEED_RST  = 24,
  parameter int SHLD_RST  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    thr_we,
  input  logic                    thr_sel,
  input  logic [E_W:0]            thr_wdata,
  input  logic                    word_valid,
  input  logic [4*E_W-1:0]        word_data,
  input  logic [CAB_W-1:0]        word_cable,
  input  logic                    word_last,
  output logic [1:0]              tw_valid,
  output logic [2*(E_W+1)-1:0]    tw_et,
  output logic [2*IDX_W-1:0]      tw_eta,
  output logic [2*IDX_W-1:0]      tw_phi,
  output logic [1:0]              tw_seed,
  output logic [1:0]              tw_shoulder,
  output logic                    evt_done,
  output logic signed [ACC_W-1:0] met_x,
  output logic signed [ACC_W-1:0] met_y,
  output logic [SUM_W-1:0]        sum_et
);
  localparam int  ET_W   = E_W + 1;
  localparam int  CPP    = N_ETA / 2;
  localparam int  N_CAB  = N_ETA * N_PHI / 2;
  localparam real PI     = 3.14159265358979;
  localparam real SCALE  = real'(1 << TRIG_FRAC);

  logic [ET_W-1:0] seed_thr, shld_thr;
  logic [ET_W-1:0] et_l [2];
  logic [1:0]      nz, is_seed, is_shld;
  logic signed [TRIG_W-1:0] cos_tab [N_PHI];
  logic signed [TRIG_W-1:0] sin_tab [N_PHI];

  for (genvar l = 0; l < 2; l++) begin : g_lane
    assign et_l[l]    = ET_W'(word_data[2*l*E_W +: E_W]) + ET_W'(word_data[(2*l+1)*E_W +: E_W]);
    assign nz[l]      = et_l[l] != '0;
    assign is_seed[l] = et_l[l] >= seed_thr;
    assign is_shld[l] = !is_seed[l] && (et_l[l] >= shld_thr);
  end

  for (genvar g = 0; g < N_PHI; g++) begin : g_trig
    localparam real ANG = 2.0 * PI * (real'(g) + 0.5) / real'(N_PHI);
    assign cos_tab[g] = TRIG_W'(int'($floor($cos(ANG) * SCALE + 0.5)));
    assign sin_tab[g] = TRIG_W'(int'($floor($sin(ANG) * SCALE + 0.5)));
  end

  logic [CAB_W-1:0] phi_full, eta_full;
  logic [IDX_W-1:0] phi, eta0, phi_sel;
  logic             cab_ok, take;
  assign cab_ok   = word_cable < CAB_W'(N_CAB);
  assign take     = word_valid && cab_ok;
  assign phi_full = word_cable / CAB_W'(CPP);
  assign eta_full = (word_cable % CAB_W'(CPP)) << 1;
  assign phi      = phi_full[IDX_W-1:0];
  assign eta0     = eta_full[IDX_W-1:0];
  assign phi_sel  = cab_ok ? phi : '0;

  logic [ET_W:0]           pair_et;
  logic signed [ACC_W-1:0] etp_s, cos_s, sin_s;
  logic signed [ACC_W-1:0] acc_x, acc_y, nx_x, nx_y;
  logic [SUM_W-1:0]        acc_s, nx_s;

  assign pair_et = (ET_W+1)'(et_l[0]) + (ET_W+1)'(et_l[1]);
  assign etp_s   = signed'(ACC_W'(pair_et));
  assign cos_s   = ACC_W'(cos_tab[phi_sel]);
  assign sin_s   = ACC_W'(sin_tab[phi_sel]);
  assign nx_x    = acc_x + (take ? etp_s * cos_s : '0);
  assign nx_y    = acc_y + (take ? etp_s * sin_s : '0);
  assign nx_s    = acc_s + (take ? SUM_W'(pair_et) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seed_thr    <= ET_W'(SEED_RST);
      shld_thr    <= ET_W'(SHLD_RST);
      tw_valid    <= '0;
      tw_et       <= '0;
      tw_eta      <= '0;
      tw_phi      <= '0;
      tw_seed     <= '0;
      tw_shoulder <= '0;
      evt_done    <= 1'b0;
      met_x       <= '0;
      met_y       <= '0;
      sum_et      <= '0;
      acc_x       <= '0;
      acc_y       <= '0;
      acc_s       <= '0;
    end else begin
      if (thr_we) begin
        if (thr_sel) shld_thr <= thr_wdata;
        else         seed_thr <= thr_wdata;
      end
      tw_valid    <= take ? nz : 2'b00;
      tw_seed     <= take ? (is_seed & nz) : 2'b00;
      tw_shoulder <= take ? (is_shld & nz) : 2'b00;
      if (take) begin
        tw_et  <= {et_l[1], et_l[0]};
        tw_eta <= {IDX_W'(eta0 + IDX_W'(1)), eta0};
        tw_phi <= {phi, phi};
      end
      evt_done <= word_valid && word_last;
      if (word_valid && word_last) begin
        met_x  <= nx_x;
        met_y  <= nx_y;
        sum_et <= nx_s;
        acc_x  <= '0;
        acc_y  <= '0;
        acc_s  <= '0;
      end else begin
        acc_x  <= nx_x;
        acc_y  <= nx_y;
        acc_s  <= nx_s;
      end
    end
  end
endmodule

// File: rtl/tower_sift_chk.sv
module tower_sift_chk #(
  parameter int ET_W  = 11,
  parameter int IDX_W = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  word_valid,
  input logic                  word_last,
  input logic [1:0]            tw_valid,
  input logic [2*ET_W-1:0]     tw_et,
  input logic [2*IDX_W-1:0]    tw_eta,
  input logic [1:0]            tw_seed,
  input logic [1:0]            tw_shoulder,
  input logic                  evt_done,
  input logic [ET_W-1:0]       seed_thr,
  input logic [ET_W-1:0]       shld_thr
);
  AST_LANE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (|tw_valid) |-> $past(word_valid)); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> $past(word_valid && word_last)); // R10
  AST_SEED_LO_THR: assert property (@(posedge clk) disable iff (!rst_n)
    tw_seed[0] |-> tw_et[ET_W-1:0] >= $past(seed_thr)); // R3
  AST_SEED_HI_THR: assert property (@(posedge clk) disable iff (!rst_n)
    tw_seed[1] |-> tw_et[2*ET_W-1:ET_W] >= $past(seed_thr)); // R3
  AST_SHLD_LO_THR: assert property (@(posedge clk) disable iff (!rst_n)
    tw_shoulder[0] |-> tw_et[ET_W-1:0] >= $past(shld_thr)); // R4
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    ((tw_seed & tw_shoulder) == 2'b00) && (((tw_seed | tw_shoulder) & ~tw_valid) == 2'b00)); // R4
  AST_NONZERO_LO: assert property (@(posedge clk) disable iff (!rst_n)
    tw_valid[0] |-> tw_et[ET_W-1:0] != '0); // R5
  AST_NONZERO_HI: assert property (@(posedge clk) disable iff (!rst_n)
    tw_valid[1] |-> tw_et[2*ET_W-1:ET_W] != '0); // R5
  AST_ETA_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (&tw_valid) |-> tw_eta[2*IDX_W-1:IDX_W] == IDX_W'(tw_eta[IDX_W-1:0] + IDX_W'(1))); // R6
endmodule

bind tower_sift tower_sift_chk #(.ET_W(E_W + 1), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .word_valid  (word_valid),
  .word_last   (word_last),
  .tw_valid    (tw_valid),
  .tw_et       (tw_et),
  .tw_eta      (tw_eta),
  .tw_seed     (tw_seed),
  .tw_shoulder (tw_shoulder),
  .evt_done    (evt_done),
  .seed_thr    (seed_thr),
  .shld_thr    (shld_thr)
);

// File: tb/test_tower_sift.sv
module test_tower_sift;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        thr_we = 1'b0, thr_sel = 1'b0;
  logic [10:0] thr_wdata = '0;
  logic        word_valid = 1'b0, word_last = 1'b0;
  logic [39:0] word_data = '0;
  logic [8:0]  word_cable = '0;
  logic [1:0]  tw_valid, tw_seed, tw_shoulder;
  logic [21:0] tw_et;
  logic [9:0]  tw_eta, tw_phi;
  logic        evt_done;
  logic signed [31:0] met_x, met_y;
  logic [23:0] sum_et;

  int vectors = 0, fails = 0;
  bit finished = 0;
  int sthr = 24, hthr = 4;
  longint ex = 0, ey = 0, es = 0;

  tower_sift i_tower_sift (.*);

  always #5 clk = ~clk;

  function automatic longint trig(int p, bit s);
    real a = 2.0 * 3.14159265358979 * (real'(p) + 0.5) / 24.0;
    return longint'($floor((s ? $sin(a) : $cos(a)) * 1024.0 + 0.5));
  endfunction

  task automatic check(string req, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(int cab, int em0, int hd0, int em1, int hd1, bit last);
    int e[2];
    int ph, et0;
    word_valid = 1'b1;
    word_last  = last;
    word_cable = 9'(cab);
    word_data  = {10'(hd1), 10'(em1), 10'(hd0), 10'(em0)};
    e[0] = em0 + hd0;
    e[1] = em1 + hd1;
    ph   = cab / 12;
    et0  = (cab % 12) * 2;
    @(negedge clk);
    for (int l = 0; l < 2; l++) begin
      bit v = (cab < 288) && (e[l] != 0);
      check("R5/R6/R7 lane valid", tw_valid[l], v);
      if (v) begin
        bit sd = e[l] >= sthr;
        bit sh = !sd && (e[l] >= hthr);
        check("R2 energy", tw_et[11*l +: 11], e[l]);
        check("R3/R4/R11 flags", {tw_seed[l], tw_shoulder[l]}, {sd, sh});
        check("R6 position", {tw_phi[5*l +: 5], tw_eta[5*l +: 5]}, {5'(ph), 5'(et0 + l)});
      end
    end
    if (cab < 288) begin
      es += e[0] + e[1];
      ex += (e[0] + e[1]) * trig(ph, 0);
      ey += (e[0] + e[1]) * trig(ph, 1);
    end
    check("R10 done strobe", evt_done, last);
    if (last) begin
      check("R8 sum_et", sum_et, es);
      check("R9 met_x", met_x, ex);
      check("R9 met_y", met_y, ey);
      ex = 0; ey = 0; es = 0;
    end
    word_valid = 1'b0;
    word_last  = 1'b0;
  endtask

  task automatic write_thr(bit sel, int val);
    thr_we = 1'b1; thr_sel = sel; thr_wdata = 11'(val);
    @(negedge clk);
    thr_we = 1'b0;
    if (sel) hthr = val; else sthr = val;
  endtask

  function automatic int rnd_e();
    int k = int'($urandom_range(0, 3));
    if (k == 0) return 0;
    if (k == 1) return int'($urandom_range(0, 30));
    return int'($urandom_range(0, 1023));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 lanes idle", tw_valid, 0);
    check("R1 done low", evt_done, 0);
    check("R1 totals zero", {met_x, met_y, 8'd0, sum_et}, 0);
    // R1/R3/R4 thresholds at their reset values, boundaries 24/23/4/3
    send(0, 20, 4, 23, 0, 0);
    send(1, 4, 0, 1, 2, 0);
    send(2, 0, 0, 1023, 1023, 1);
    // R7 idle cycle with data present changes nothing
    word_data = 40'hFF_FFFF_FFFF; word_cable = 9'd5;
    @(negedge clk);
    check("R7 idle no lane", tw_valid, 0);
    check("R7 idle no done", evt_done, 0);
    // R6 out-of-range cable ignored, then event closes with totals of one word
    send(300, 500, 500, 500, 500, 0);
    send(13, 7, 9, 0, 0, 1);
    // R11 threshold writes
    write_thr(0, 5);
    write_thr(1, 1);
    send(40, 5, 0, 1, 0, 0);
    send(41, 4, 0, 0, 0, 1);
    write_thr(0, 24);
    write_thr(1, 4);
    // full detector at maximum energy
    for (int c = 0; c < 288; c++) send(c, 1023, 1023, 1023, 1023, c == 287);
    // random events back to back
    for (int ev = 0; ev < 60; ev++) begin
      int n = int'($urandom_range(1, 30));
      for (int w = 0; w < n; w++)
        send(int'($urandom_range(0, 295)), rnd_e(), rnd_e(), rnd_e(), rnd_e(), w == n - 1);
      if ($urandom_range(0, 1) == 0) @(negedge clk);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule